// File: doc/BRIEF.md
# Radix-2 Decimation-in-Frequency Pipeline Stage

This block is one stage of a streaming radix-2 decimation-in-frequency FFT of size N. It takes one complex sample per enabled clock. Samples are framed by an input sync pulse, and it produces one complex sample per enabled clock. During the first half of each frame it parks the incoming samples in a half-frame buffer. During the second half it pairs each new sample with the one that arrived N/2 samples earlier. The pair and a twiddle factor from a ROM built at elaboration go into a two-register butterfly.

A tag travels through the butterfly with the first pair of each frame. When the tag comes out, the stage sends the N/2 sums straight to its output and stores the N/2 twiddled differences in a second half-frame buffer. It then replays those differences while the next frame fills the input buffer, so the output stream has no gaps. Stages of this kind are chained, each one with half the N of the stage before it, to form a complete transform.

Top module: `dif_stage`

## Requirements
- R1: While rst_ni is low (asynchronous, active low), data_o and sync_o are zero, and they stay zero after release until the stage produces its first result.
- R2: Samples are packed with the real part in the upper half and the imaginary part in the lower half, both signed two's complement. Input parts are IW bits wide and output parts IW+2 bits wide. Full-scale inputs of either sign give results with no wrap.
- R3: Samples accepted before the first sync_i have no effect. No sync_o is produced until a frame has started with sync_i high on an enabled clock.
- R4: Within a frame of samples x[0..N-1], with x[0] taken when sync_i is high, output samples 0..N/2-1 are x[n]+x[n+N/2] for n = 0..N/2-1, computed exactly.
- R5: Output samples N/2..N-1 are d[n]·W[n] for n = 0..N/2-1, where d[n] = x[n]-x[n+N/2]. W[n] = wr + j·wi, with wr = floor(2^(CW-2)·cos(2πn/N)+0.5) and wi = -floor(2^(CW-2)·sin(2πn/N)+0.5). Each part of the complex product is arithmetically shifted right by CW-2, rounding toward minus infinity.
- R6: Count as enabled clock 0 the one that takes x[0]. Output sample k of the frame is on data_o after enabled clock N/2+2+k.
- R7: sync_o is high on output sample 0 of every frame and low on every other output. Frames follow one another every N enabled clocks without a new sync_i.
- R8: When ce_i is low, no state changes: data_o and sync_o hold, and data_i and sync_i are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_i | input | 1 | Clock enable; one sample in and one out per high cycle |
| sync_i | input | 1 | Marks the first sample of a frame |
| data_i | input | 2*IW | Input sample, real part in the upper half, imaginary part in the lower half |
| data_o | output | 2*(IW+2) | Output sample, same packing |
| sync_o | output | 1 | Marks output sample 0 of a frame |

## Verification
The bench builds the stage with N=16, IW=8 and CW=10. This gives an eight-entry twiddle ROM with exact entries (0° and 90°) and rounded entries (22.5°, 45°, 67.5°), and it makes a 4-bit position counter wrap between back-to-back frames. With 8-bit inputs, opposite full-scale values drive the difference path to its largest magnitude at the 45° entry, so the IW+2 output width is tested at its edge. Random idle gaps in ce_i, with sync_i and data_i toggled during those gaps, show that the output timing is counted in enabled clocks only.

// File: rtl/dif_stage_pkg.sv
`timescale 1ns/1ps
package dif_stage_pkg;

  localparam real PI = 3.14159265358979323846;

  typedef enum logic {HALF_FILL = 1'b0, HALF_PAIR = 1'b1} half_e;

  // Power series, accurate for |x| <= pi
  function automatic real trig_series(real x, bit want_sin);
    real term;
    real acc;
    int  k0;
    k0   = want_sin ? 1 : 0;
    term = want_sin ? x : 1.0;
    acc  = term;
    for (int k = 1; k < 24; k++) begin
      term = -term * x * x / (real'(2*k + k0 - 1) * real'(2*k + k0));
      acc  = acc + term;
    end
    return acc;
  endfunction

  function automatic int round_half_up(real x);
    real t;
    int  i;
    t = x + 0.5;
    i = $rtoi(t);
    if (real'(i) > t) i = i - 1;
    return i;
  endfunction

  function automatic int twiddle_part(int idx, int npts, int cw, bit want_sin);
    real ang;
    ang = 2.0 * PI * real'(idx) / real'(npts);
    return round_half_up(real'(1 << (cw - 2)) * trig_series(ang, want_sin));
  endfunction

endpackage

// File: rtl/dif_twiddle_rom.sv
`timescale 1ns/1ps
module dif_twiddle_rom #(
  parameter int N  = 16,
  parameter int CW = 10
) (
  input  logic [$clog2(N/2)-1:0] idx_i,
  output logic signed [CW-1:0]   wr_o,
  output logic signed [CW-1:0]   wi_o
);
  localparam int HALF = N / 2;

  logic signed [CW-1:0] rom_re [HALF];
  logic signed [CW-1:0] rom_im [HALF];

  for (genvar k = 0; k < HALF; k++) begin : g_rom
    localparam int C_RE = dif_stage_pkg::twiddle_part(k, N, CW, 1'b0);
    localparam int C_IM = -dif_stage_pkg::twiddle_part(k, N, CW, 1'b1);
    assign rom_re[k] = CW'(C_RE);
    assign rom_im[k] = CW'(C_IM);
  end

  assign wr_o = rom_re[idx_i];
  assign wi_o = rom_im[idx_i];
endmodule

// File: rtl/dif_pair_buffer.sv
`timescale 1ns/1ps
module dif_pair_buffer
  import dif_stage_pkg::*;
#(
  parameter int N  = 16,
  parameter int IW = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    ce_i,
  input  logic                    sync_i,
  input  logic [2*IW-1:0]         data_i,
  output logic [2*IW-1:0]         early_o,
  output logic [2*IW-1:0]         late_o,
  output logic [$clog2(N/2)-1:0]  idx_o,
  output logic                    tag_o
);
  localparam int HALF = N / 2;
  localparam int AW   = $clog2(N);
  localparam int HW   = AW - 1;

  logic [AW-1:0]   cnt_q;
  logic            run_q;
  logic [AW-1:0]   pos;
  logic            active;
  half_e           ph;
  logic [HW-1:0]   slot;
  logic [2*IW-1:0] mem_q [HALF];

  // sync_i realigns the frame position to zero
  assign pos    = sync_i ? '0 : cnt_q;
  assign active = sync_i | run_q;
  assign ph     = half_e'(pos[AW-1]);
  assign slot   = pos[HW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (ce_i && active) begin
      cnt_q <= pos + AW'(1);
      run_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (ce_i && active && ph == HALF_FILL) mem_q[slot] <= data_i;
  end

  assign early_o = mem_q[slot];
  assign late_o  = data_i;
  assign idx_o   = slot;
  assign tag_o   = active && ph == HALF_PAIR && slot == '0;
endmodule

// File: rtl/dif_butterfly.sv
`timescale 1ns/1ps
module dif_butterfly #(
  parameter int IW = 8,
  parameter int CW = 10,
  parameter int OW = IW + 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 ce_i,
  input  logic [2*IW-1:0]      a_i,
  input  logic [2*IW-1:0]      b_i,
  input  logic signed [CW-1:0] wr_i,
  input  logic signed [CW-1:0] wi_i,
  input  logic                 tag_i,
  output logic [2*OW-1:0]      sum_o,
  output logic [2*OW-1:0]      diff_o,
  output logic                 tag_o
);
  localparam int SW = IW + 1;
  localparam int PW = OW + CW;

  logic signed [IW-1:0] a_re, a_im, b_re, b_im;
  logic signed [SW-1:0] s_re_q, s_im_q, d_re_q, d_im_q;
  logic signed [CW-1:0] w_re_q, w_im_q;
  logic                 tag1_q;
  logic signed [PW-1:0] p_re, p_im, p_re_sh, p_im_sh;
  logic [2*OW-1:0]      sum_q, diff_q;
  logic                 tag2_q;

  assign a_re = a_i[2*IW-1:IW];
  assign a_im = a_i[IW-1:0];
  assign b_re = b_i[2*IW-1:IW];
  assign b_im = b_i[IW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s_re_q <= '0; s_im_q <= '0;
      d_re_q <= '0; d_im_q <= '0;
      w_re_q <= '0; w_im_q <= '0;
      tag1_q <= 1'b0;
    end else if (ce_i) begin
      s_re_q <= SW'(a_re) + SW'(b_re);
      s_im_q <= SW'(a_im) + SW'(b_im);
      d_re_q <= SW'(a_re) - SW'(b_re);
      d_im_q <= SW'(a_im) - SW'(b_im);
      w_re_q <= wr_i;
      w_im_q <= wi_i;
      tag1_q <= tag_i;
    end
  end

  // |W| <= 2^(CW-2), so the scaled product fits in OW bits
  assign p_re    = PW'(d_re_q) * PW'(w_re_q) - PW'(d_im_q) * PW'(w_im_q);
  assign p_im    = PW'(d_re_q) * PW'(w_im_q) + PW'(d_im_q) * PW'(w_re_q);
  assign p_re_sh = p_re >>> (CW - 2);
  assign p_im_sh = p_im >>> (CW - 2);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_q  <= '0;
      diff_q <= '0;
      tag2_q <= 1'b0;
    end else if (ce_i) begin
      sum_q  <= {OW'(s_re_q), OW'(s_im_q)};
      diff_q <= {OW'(p_re_sh), OW'(p_im_sh)};
      tag2_q <= tag1_q;
    end
  end

  assign sum_o  = sum_q;
  assign diff_o = diff_q;
  assign tag_o  = tag2_q;
endmodule

// File: rtl/dif_reorder.sv
`timescale 1ns/1ps
module dif_reorder
  import dif_stage_pkg::*;
#(
  parameter int N  = 16,
  parameter int OW = 10
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ce_i,
  input  logic [2*OW-1:0] sum_i,
  input  logic [2*OW-1:0] diff_i,
  input  logic            tag_i,
  output logic [2*OW-1:0] data_o,
  output logic            sync_o
);
  localparam int HALF = N / 2;
  localparam int AW   = $clog2(N);
  localparam int HW   = AW - 1;

  logic [AW-1:0]   cnt_q;
  logic            run_q;
  logic [AW-1:0]   pos;
  logic            active;
  half_e           ph;
  logic [HW-1:0]   slot;
  logic [2*OW-1:0] mem_q [HALF];
  logic [2*OW-1:0] data_q;
  logic            sync_q;

  assign pos    = tag_i ? '0 : cnt_q;
  assign active = tag_i | run_q;
  assign ph     = half_e'(pos[AW-1]);
  assign slot   = pos[HW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      run_q  <= 1'b0;
      data_q <= '0;
      sync_q <= 1'b0;
    end else if (ce_i && active) begin
      cnt_q <= pos + AW'(1);
      run_q <= 1'b1;
      if (ph == HALF_FILL) begin
        data_q <= sum_i;
        sync_q <= tag_i;
      end else begin
        data_q <= mem_q[slot];
        sync_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (ce_i && active && ph == HALF_FILL) mem_q[slot] <= diff_i;
  end

  assign data_o = data_q;
  assign sync_o = sync_q;
endmodule

// File: rtl/dif_stage.sv
`timescale 1ns/1ps
module dif_stage #(
  parameter int N  = 16,
  parameter int IW = 8,
  parameter int CW = 10
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  ce_i,
  input  logic                  sync_i,
  input  logic [2*IW-1:0]       data_i,
  output logic [2*(IW+2)-1:0]   data_o,
  output logic                  sync_o
);
  localparam int OW = IW + 2;
  localparam int HW = $clog2(N / 2);

  logic [2*IW-1:0]      pair_a, pair_b;
  logic [HW-1:0]        tw_idx;
  logic                 pair_tag;
  logic signed [CW-1:0] w_re, w_im;
  logic [2*OW-1:0]      bf_sum, bf_diff;
  logic                 bf_tag;

  dif_pair_buffer #(.N(N), .IW(IW)) u_pair (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ce_i    (ce_i),
    .sync_i  (sync_i),
    .data_i  (data_i),
    .early_o (pair_a),
    .late_o  (pair_b),
    .idx_o   (tw_idx),
    .tag_o   (pair_tag)
  );

  dif_twiddle_rom #(.N(N), .CW(CW)) u_rom (
    .idx_i (tw_idx),
    .wr_o  (w_re),
    .wi_o  (w_im)
  );

  dif_butterfly #(.IW(IW), .CW(CW), .OW(OW)) u_bfly (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ce_i   (ce_i),
    .a_i    (pair_a),
    .b_i    (pair_b),
    .wr_i   (w_re),
    .wi_i   (w_im),
    .tag_i  (pair_tag),
    .sum_o  (bf_sum),
    .diff_o (bf_diff),
    .tag_o  (bf_tag)
  );

  dif_reorder #(.N(N), .OW(OW)) u_reorder (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ce_i   (ce_i),
    .sum_i  (bf_sum),
    .diff_i (bf_diff),
    .tag_i  (bf_tag),
    .data_o (data_o),
    .sync_o (sync_o)
  );
endmodule

// File: rtl/dif_stage_chk.sv
`timescale 1ns/1ps
module dif_stage_chk #(
  parameter int DW = 20
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          ce_i,
  input logic          sync_i,
  input logic [DW-1:0] data_o,
  input logic          sync_o,
  input logic          bf_tag_i
);
  logic seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               seen_q <= 1'b0;
    else if (ce_i && sync_i)   seen_q <= 1'b1;
  end

  assert_no_early_sync_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seen_q |-> !sync_o);

  assert_sync_from_bfly_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sync_o) |-> $past(ce_i && bf_tag_i));

  assert_sync_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_i && sync_o) |=> !sync_o);

  assert_hold_when_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce_i |=> ($stable(data_o) && $stable(sync_o)));
endmodule

bind dif_stage dif_stage_chk #(.DW(2*(IW+2))) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .ce_i     (ce_i),
  .sync_i   (sync_i),
  .data_o   (data_o),
  .sync_o   (sync_o),
  .bf_tag_i (bf_tag)
);

// File: tb/dif_stage_tb_top.sv
`timescale 1ns/1ps
module dif_stage_tb_top;
  localparam int  N    = 16;
  localparam int  IW   = 8;
  localparam int  CW   = 10;
  localparam int  OW   = IW + 2;
  localparam int  HALF = N / 2;
  localparam int  MAXF = 4;
  localparam real PI_R = 3.14159265358979323846;

  logic              clk_i  = 1'b0;
  logic              rst_ni = 1'b0;
  logic              ce_i   = 1'b0;
  logic              sync_i = 1'b0;
  logic [2*IW-1:0]   data_i = '0;
  logic [2*OW-1:0]   data_o;
  logic              sync_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  int in_re [MAXF*N];
  int in_im [MAXF*N];
  int ex_re [MAXF*N];
  int ex_im [MAXF*N];

  always #2.5 clk_i = ~clk_i;

  dif_stage #(.N(N), .IW(IW), .CW(CW)) dut_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ce_i   (ce_i),
    .sync_i (sync_i),
    .data_i (data_i),
    .data_o (data_o),
    .sync_o (sync_o)
  );

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int out_re();
    return int'($signed(data_o[2*OW-1:OW]));
  endfunction

  function automatic int out_im();
    return int'($signed(data_o[OW-1:0]));
  endfunction

  function automatic int tw_re(int n);
    return $rtoi($floor(real'(1 << (CW-2)) * $cos(2.0*PI_R*real'(n)/real'(N)) + 0.5));
  endfunction

  function automatic int tw_im(int n);
    return -$rtoi($floor(real'(1 << (CW-2)) * $sin(2.0*PI_R*real'(n)/real'(N)) + 0.5));
  endfunction

  task automatic build_expected(int nfr);
    for (int f = 0; f < nfr; f++) begin
      for (int n = 0; n < HALF; n++) begin
        int a_re, a_im, b_re, b_im, d_re, d_im;
        a_re = in_re[f*N+n];      a_im = in_im[f*N+n];
        b_re = in_re[f*N+n+HALF]; b_im = in_im[f*N+n+HALF];
        d_re = a_re - b_re;       d_im = a_im - b_im;
        ex_re[f*N+n]      = a_re + b_re;
        ex_im[f*N+n]      = a_im + b_im;
        ex_re[f*N+HALF+n] = (d_re*tw_re(n) - d_im*tw_im(n)) >>> (CW-2);
        ex_im[f*N+HALF+n] = (d_re*tw_im(n) + d_im*tw_re(n)) >>> (CW-2);
      end
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    ce_i = 1'b0; sync_i = 1'b0; rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic idle_gaps(int gap_pct);
    if (gap_pct > 0 && int'($urandom % 100) < gap_pct) begin
      int len;
      len = 1 + int'($urandom % 3);
      for (int g = 0; g < len; g++) begin
        logic [2*OW-1:0] hold_d;
        logic            hold_s;
        @(negedge clk_i);
        ce_i   = 1'b0;
        sync_i = 1'($urandom);
        data_i = (2*IW)'($urandom);
        hold_d = data_o;
        hold_s = sync_o;
        @(posedge clk_i); #1;
        chk(data_o == hold_d, "R8", "data held while idle", longint'(data_o), longint'(hold_d));
        chk(sync_o == hold_s, "R8", "sync held while idle", longint'(sync_o), longint'(hold_s));
      end
    end
  endtask

  task automatic drive_enabled(bit s, int re, int im);
    @(negedge clk_i);
    ce_i   = 1'b1;
    sync_i = s;
    data_i = {IW'(re), IW'(im)};
    @(posedge clk_i); #1;
  endtask

  task automatic run_case(int nfr, int pre, int gap_pct);
    int total;
    total = nfr * N;
    build_expected(nfr);
    do_reset();
    for (int p = 0; p < pre; p++) begin
      idle_gaps(gap_pct);
      drive_enabled(1'b0, int'($urandom % 256) - 128, int'($urandom % 256) - 128);
      chk(sync_o == 1'b0, "R3", "sync before any input sync", longint'(sync_o), 0);
    end
    for (int t = 0; t < total + HALF + 2; t++) begin
      idle_gaps(gap_pct);
      if (t < total) drive_enabled(t == 0, in_re[t], in_im[t]);
      else           drive_enabled(1'b0, 0, 0);
      if (t >= HALF + 2) begin
        int    j;
        string req;
        j   = t - HALF - 2;
        req = ((j % N) < HALF) ? "R4" : "R5";
        chk(out_re() == ex_re[j], req, $sformatf("real part of output %0d (R6 timing)", j),
            out_re(), ex_re[j]);
        chk(out_im() == ex_im[j], req, $sformatf("imag part of output %0d (R6 timing)", j),
            out_im(), ex_im[j]);
        chk(sync_o == ((j % N) == 0), "R7", $sformatf("sync on output %0d", j),
            longint'(sync_o), longint'((j % N) == 0));
      end else begin
        chk(sync_o == 1'b0, "R7", "sync low before first result", longint'(sync_o), 0);
      end
    end
    @(negedge clk_i);
    ce_i = 1'b0; sync_i = 1'b0;
  endtask

  task automatic test_impulse();
    for (int i = 0; i < N; i++) begin in_re[i] = 0; in_im[i] = 0; end
    in_re[0] = 100;
    in_im[3] = -37;
    run_case(1, 0, 0);
  endtask

  task automatic test_reset();
    // Reset asserted between edges must clear outputs at once (R1)
    @(posedge clk_i); #1;
    rst_ni = 1'b0;
    #1;
    chk(data_o == '0, "R1", "data cleared by async reset", longint'(data_o), 0);
    chk(sync_o == 1'b0, "R1", "sync cleared by async reset", longint'(sync_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (3) begin
      @(posedge clk_i); #1;
      chk(data_o == '0, "R1", "data zero after release", longint'(data_o), 0);
      chk(sync_o == 1'b0, "R1", "sync zero after release", longint'(sync_o), 0);
    end
  endtask

  task automatic test_extremes();
    for (int f = 0; f < 2; f++) begin
      for (int n = 0; n < N; n++) begin
        bit hi;
        hi = (n < HALF) ^ (f == 1);
        in_re[f*N+n] = hi ? 127 : -128;
        in_im[f*N+n] = hi ? -128 : 127;
      end
    end
    run_case(2, 0, 0); // full-scale difference path, R2 packing and width
  endtask

  task automatic test_random_stream();
    for (int i = 0; i < 3*N; i++) begin
      in_re[i] = int'($urandom % 256) - 128;
      in_im[i] = int'($urandom % 256) - 128;
    end
    run_case(3, 0, 0);
  endtask

  task automatic test_ce_gaps();
    for (int i = 0; i < 2*N; i++) begin
      in_re[i] = int'($urandom % 256) - 128;
      in_im[i] = int'($urandom % 256) - 128;
    end
    run_case(2, 0, 40); // R8 idle cycles interleaved
  endtask

  task automatic test_presync();
    for (int i = 0; i < N; i++) begin
      in_re[i] = int'($urandom % 256) - 128;
      in_im[i] = int'($urandom % 256) - 128;
    end
    run_case(1, 5, 0); // R3 samples ahead of the first sync
  endtask

  initial begin
    test_impulse();
    test_reset();
    test_extremes();
    test_random_stream();
    test_ce_gaps();
    test_presync();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(100000 * 5);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule